// File: doc/BRIEF.md
# Stochastic Spin Update Engine

This block performs single-flip Gibbs sampling over a bank of binary spins. On every active clock it presents the index of one spin to an external interaction unit. That unit returns the signed energy change ΔH for that spin, defined as the energy with the spin at 1 minus the energy with the spin at 0. The block uses ΔH to look up a 16-bit acceptance probability in a rewritable table. It then compares that probability against a 16-bit pseudorandom word. The result is written as the new spin value, and the index moves on to the next spin.

The table holds sigmoid(-ΔH/T) with the temperature already folded in. Software loads a new table through a plain write port to change temperature. After reset, the engine first fills every spin with a pseudorandom bit, one spin per clock. Only then does it accept update cycles. The `run` input gates the sampling. A one-cycle pulse marks the end of each full sweep, and a counter records completed sweeps.

Top module: `spin_gibbs_unit`

## Requirements
- R1: While reset is asserted, `spins`, `upd_idx`, `sweep_done` and `sweep_cnt` are all zero.
- R2: After reset is released, the engine spends NSPIN cycles on a seeding pass whatever `run` is. In that pass, spin k receives bit 0 of the generator state after k advances from the seed. Afterwards `upd_idx` is 0 and no sweep has been counted.
- R3: On an update cycle, the selected spin becomes 1 exactly when the table entry is strictly greater than the current random word. Otherwise it becomes 0, so an entry equal to the random word gives 0.
- R4: `dh` is two's complement, and the table address is its bit pattern taken as unsigned. ΔH = -1 (0xFF) therefore reads entry 255, and ΔH = +1 reads entry 1.
- R5: The random word comes from a 16-bit shift register. It shifts left and takes in the XOR of bits 15, 14, 12 and 3 as its new bit 0. It starts at the seed and advances once per seeding step and once per update, never otherwise.
- R6: An update cycle is a cycle with `run` high after seeding. Each one writes the spin at `upd_idx` and then steps `upd_idx` by one, wrapping from NSPIN-1 to 0.
- R7: The update that writes spin NSPIN-1 causes `sweep_done` to be high for exactly the next cycle. On that same edge `sweep_cnt` increases by one.
- R8: With `run` low after seeding, the spins, the index and the random sequence do not change.
- R9: A table write takes effect on the following clock edge. An update in the same cycle as a write to its own entry uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables one update per clock after seeding |
| dh | input | EW | Two's complement ΔH for the spin at `upd_idx` |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | EW | Table write address |
| tbl_data | input | 16 | Table write data |
| upd_idx | output | IW | Index of the spin being updated this cycle |
| spins | output | NSPIN | Current spin values, bit k is spin k |
| sweep_done | output | 1 | One-cycle pulse after the last spin of a sweep is written |
| sweep_cnt | output | CW | Number of completed sweeps |

## Verification
The hardest case to reach from the ports is the strict comparison, where the table entry exactly equals the random word. The random word cannot be seen at the ports. The bench therefore runs its own copy of the shift register from the known seed. Just before an update, it writes the entry that ΔH will select with the predicted random word, and the expected result is 0. Writing the predicted word plus one gives 1. A write and an update to the same entry in one cycle shows which table contents the decision uses. Long stretches with `run` low, followed by a resumed sweep, show that the random sequence did not move.

// File: rtl/gibbs_pkg.sv
package gibbs_pkg;
    localparam int PROB_W = 16;

    typedef logic [PROB_W-1:0] prob_t;

    // one step of the 16-bit maximal-length shift register
    function automatic prob_t lfsr_step(input prob_t s);
        logic fb;
        fb = s[15] ^ s[14] ^ s[12] ^ s[3];
        return {s[14:0], fb};
    endfunction
endpackage

// File: rtl/lfsr_gen.sv
module lfsr_gen
    import gibbs_pkg::*;
#(
    parameter prob_t SEED = 16'h1D2B
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output prob_t value
);
    prob_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv) state_d = lfsr_step(state_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign value = state_q;

    // R5: a nonzero seed never reaches the all-zero lockup state
    a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R5: state only moves when advanced
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state_q));
endmodule

// File: rtl/sig_table.sv
module sig_table
    import gibbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  prob_t         wdata,
    input  logic [AW-1:0] raddr,
    output prob_t         rdata
);
    localparam int DEPTH = 1 << AW;

    prob_t mem_d [DEPTH];
    prob_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];

    // R9: a write lands on the next edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/spin_bank.sv
module spin_bank #(
    parameter int NSPIN = 16,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic             wbit,
    output logic [NSPIN-1:0] spins
);
    logic [NSPIN-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (we) bits_d[widx] = wbit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign spins = bits_q;

    // R8: without a write nothing moves
    a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bits_q));

    // R6: at most one bit changes per edge
    a_r6_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bits_q ^ $past(bits_q)) <= 1);
endmodule

// File: rtl/spin_gibbs_unit.sv
module spin_gibbs_unit
    import gibbs_pkg::*;
#(
    parameter int    NSPIN = 16,
    parameter int    EW    = 8,
    parameter int    CW    = 16,
    parameter prob_t SEED  = 16'h1D2B,
    localparam int   IW    = (NSPIN > 1) ? $clog2(NSPIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EW-1:0]    dh,
    input  logic             tbl_we,
    input  logic [EW-1:0]    tbl_addr,
    input  logic [15:0]      tbl_data,
    output logic [IW-1:0]    upd_idx,
    output logic [NSPIN-1:0] spins,
    output logic             sweep_done,
    output logic [CW-1:0]    sweep_cnt
);
    localparam logic [IW-1:0] LAST = IW'(NSPIN - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          seeding;
        logic          done;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    prob_t prob, rnd;
    logic  upd, step, at_last, accept, wbit;

    assign upd     = run && !ctl_q.seeding;
    assign step    = upd || ctl_q.seeding;
    assign at_last = (ctl_q.idx == LAST);
    assign accept  = (prob > rnd);
    assign wbit    = ctl_q.seeding ? rnd[0] : accept;

    sig_table #(.AW(EW)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (dh),
        .rdata (prob)
    );

    lfsr_gen #(.SEED(SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (step),
        .value (rnd)
    );

    spin_bank #(.NSPIN(NSPIN), .IW(IW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (step),
        .widx  (ctl_q.idx),
        .wbit  (wbit),
        .spins (spins)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (step) ctl_d.idx = at_last ? '0 : ctl_q.idx + 1'b1;
        if (ctl_q.seeding && at_last) ctl_d.seeding = 1'b0;
        if (upd && at_last) begin
            ctl_d.done = 1'b1;
            ctl_d.cnt  = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.idx     <= '0;
            ctl_q.seeding <= 1'b1;
            ctl_q.done    <= 1'b0;
            ctl_q.cnt     <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign upd_idx    = ctl_q.idx;
    assign sweep_done = ctl_q.done;
    assign sweep_cnt  = ctl_q.cnt;

    // R3: the written spin follows the strict comparison of table and random word
    a_r3_decision: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> spins[$past(ctl_q.idx)] == $past(prob > rnd));

    // R7: the sweep pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);

    // R7: count steps with each pulse
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> sweep_cnt == $past(sweep_cnt) + 1'b1);

    // R8: idle cycles after seeding change neither index nor spins
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctl_q.seeding) |=> ($stable(upd_idx) && $stable(spins)));

    // R2: no sweep is counted while seeding
    a_r2_no_pulse_seeding: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.seeding |-> (sweep_cnt == '0 && !sweep_done));
endmodule

// File: tb/sim_spin_gibbs_unit.sv
module sim_spin_gibbs_unit;
    localparam int          N    = 16;
    localparam int          IWB  = 4;
    localparam logic [15:0] SEED = 16'h1D2B;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run = 1'b0;
    logic [7:0]     dh = '0;
    logic           tbl_we = 1'b0;
    logic [7:0]     tbl_addr = '0;
    logic [15:0]    tbl_data = '0;
    logic [IWB-1:0] upd_idx;
    logic [N-1:0]   spins;
    logic           sweep_done;
    logic [15:0]    sweep_cnt;

    int total = 0;
    int bad = 0;

    // reference model
    logic [15:0]    m_rng;
    logic [15:0]    m_tbl [256];
    logic [N-1:0]   m_spins;
    int             m_idx;
    logic           m_done;
    int             m_cnt;

    always #10 clk = ~clk;

    spin_gibbs_unit #(.NSPIN(N), .EW(8), .CW(16), .SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .dh(dh),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .upd_idx(upd_idx), .spins(spins),
        .sweep_done(sweep_done), .sweep_cnt(sweep_cnt)
    );

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " spins"}, 64'(spins), 64'(m_spins));
        chk({tag, " idx"}, 64'(upd_idx), 64'(m_idx));
        chk({tag, " done"}, 64'(sweep_done), 64'(m_done));
        chk({tag, " cnt"}, 64'(sweep_cnt), 64'(m_cnt));
    endtask

    // one clock: drive at negedge, advance model, compare at the next negedge
    task automatic cyc(input logic r, input logic [7:0] d, input logic we,
                       input logic [7:0] wa, input logic [15:0] wd, input string tag);
        logic upd;
        run = r; dh = d; tbl_we = we; tbl_addr = wa; tbl_data = wd;
        upd = r;
        @(posedge clk);
        @(negedge clk);
        m_done = 1'b0;
        if (upd) begin
            m_spins[m_idx] = (m_tbl[d] > m_rng);
            m_rng = nxt(m_rng);
            if (m_idx == N - 1) begin
                m_idx = 0; m_done = 1'b1; m_cnt++;
            end else m_idx++;
        end
        if (we) m_tbl[wa] = wd;
        run = 1'b0; tbl_we = 1'b0;
        check_all(tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v);
        cyc(1'b0, 8'h00, 1'b1, a, v, "R9 write");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 spins", 64'(spins), 0);
        chk("R1 idx", 64'(upd_idx), 0);
        chk("R1 done", 64'(sweep_done), 0);
        chk("R1 cnt", 64'(sweep_cnt), 0);
    endtask

    task automatic t_seed;
        m_rng = SEED; m_spins = '0; m_idx = 0; m_done = 0; m_cnt = 0;
        for (int i = 0; i < 256; i++) m_tbl[i] = '0;
        for (int k = 0; k < N; k++) begin
            m_spins[k] = m_rng[0];
            m_rng = nxt(m_rng);
        end
        rst_n = 1'b1;
        repeat (N) @(posedge clk);
        @(negedge clk);
        check_all("R2 seeding");
    endtask

    task automatic t_zero_table;
        // all entries zero: every update gives 0, one sweep completes
        for (int i = 0; i < N; i++) cyc(1'b1, 8'(i * 17), 1'b0, 0, 0, "R3 R6 zero table");
        chk("R7 sweep pulse", 64'(sweep_done), 1);
        chk("R3 all zero", 64'(spins), 0);
        cyc(1'b0, 0, 1'b0, 0, 0, "R7 pulse ends");
    endtask

    task automatic t_signed_index;
        wr(8'hFF, 16'hFFFF);
        wr(8'h01, 16'h0000);
        for (int i = 0; i < N; i++) cyc(1'b1, 8'hFF, 1'b0, 0, 0, "R4 dh=-1 entry 255");
        for (int i = 0; i < N / 2; i++) cyc(1'b1, 8'h01, 1'b0, 0, 0, "R4 dh=+1 entry 1");
    endtask

    task automatic t_strict;
        // entry equal to the upcoming random word gives 0, one above gives 1
        wr(8'h40, m_rng);
        cyc(1'b1, 8'h40, 1'b0, 0, 0, "R3 equal gives zero");
        wr(8'h41, m_rng + 16'd1);
        cyc(1'b1, 8'h41, 1'b0, 0, 0, "R3 above gives one");
        wr(8'h42, m_rng - 16'd1);
        cyc(1'b1, 8'h42, 1'b0, 0, 0, "R3 below gives zero");
    endtask

    task automatic t_hold;
        for (int i = 0; i < 7; i++) cyc(1'b0, 8'hFF, 1'b0, 0, 0, "R8 idle hold");
        // resumed updates must continue the random sequence unchanged (R5)
        wr(8'h20, 16'h8000);
        for (int i = 0; i < 2 * N; i++) cyc(1'b1, 8'h20, 1'b0, 0, 0, "R5 sequence after idle");
    endtask

    task automatic t_write_collide;
        wr(8'h33, 16'h0000);
        // update reads old zero entry while writing all ones to it
        cyc(1'b1, 8'h33, 1'b1, 8'h33, 16'hFFFF, "R9 same-cycle uses old");
        cyc(1'b1, 8'h33, 1'b0, 0, 0, "R9 new value next cycle");
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_seed();
        t_zero_table();
        t_signed_index();
        t_strict();
        t_hold();
        t_write_collide();
        for (int i = 0; i < 3 * N; i++) cyc(1'b1, 8'(i), 1'b0, 0, 0, "R6 R7 extra sweeps");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule